// File: doc/BRIEF.md
# LZW Stream Encoder

The block turns a stream of fixed-width characters into a stream of LZW dictionary codes. Its dictionary is a back-pointer table: an entry addressed by the pair (current code, next character) is either empty or holds the code that stands for the current string followed by that character. One character enters per valid/ready beat. A code leaves on a one-cycle output valid pulse, and the last code of a stream carries an output last flag.

Each lookup is assumed to miss. Under that assumption the encoder can take a new character in the same cycle that it resolves the previous lookup, so a run of misses streams at one character per clock. A lookup that hits changes the current code, and input then pauses for one cycle. The table is indexed directly by the concatenation {code, character}. The defaults are 2-bit characters and 6-bit codes, which gives 256 entries; the widths are parameters. The dictionary is cleared after every stream and also whenever the code space runs out.

Top module: `lzw_enc`

## Requirements
- R1: After reset, and after a reset asserted in the middle of a stream, out_valid_o is low, in_ready_o is high and the dictionary is empty.
- R2: The first character of a stream sets the current code to that character's value; a stream of a single character emits that value with out_last_o set.
- R3: When q(current code, next character) is empty, the encoder emits the current code and then takes the next character's value as the current code. Single-symbol codes equal the character value.
- R4: When q(current code, next character) holds a code, that code becomes the current code and nothing is emitted.
- R5: Codes added to the dictionary start at 2^CHAR_W and rise by one with each add.
- R6: At the end of a stream, marked by in_last_i on the final character, the current code is emitted once with out_last_o high. No other code carries out_last_o.
- R7: While every lookup misses, in_ready_o stays high and one character is accepted on every clock.
- R8: A hit that resolves while the next character is already waiting holds in_ready_o low for exactly one cycle.
- R9: A miss that finds no free code (the next code would equal 2^CODE_W) emits the current code, writes no entry, clears the dictionary and restarts code assignment at 2^CHAR_W.
- R10: After the final code of a stream the dictionary is cleared. in_ready_o is low for 2^(CODE_W+CHAR_W) cycles, counted from the cycle in which the final code appears.
- R11: Emptiness is a separate valid bit per entry. A code written into an entry is seen by a lookup of that same entry in the very next cycle.
- R12: Streams are independent: the same input stream always yields the same codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input character is valid |
| in_ready_o | output | 1 | Encoder accepts a character on this edge |
| in_char_i | input | CHAR_W | Input character |
| in_last_i | input | 1 | Character is the final one of its stream |
| out_valid_o | output | 1 | Output code is valid this cycle |
| out_code_o | output | CODE_W | Emitted dictionary code |
| out_last_o | output | 1 | Emitted code is the final one of its stream |

## Verification
The checks assume that every stream holds at least one character and ends with in_last_i. They also assume that in_valid_i, in_char_i and in_last_i stay steady while in_ready_o is low, and that no character arrives before the clear that follows a stream has finished. The stimulus drives a character only through the handshake and keeps it in place while waiting. It waits for in_ready_o to return before it starts a new stream, and it asserts in_last_i only on the final character of each stream.

// File: rtl/lzw_pkg.sv
package lzw_pkg;
  localparam int unsigned CHAR_W_DEF = 2;
  localparam int unsigned CODE_W_DEF = 6;
endpackage

// File: rtl/lzw_bptab.sv
module lzw_bptab #(
  parameter int unsigned CHAR_W = lzw_pkg::CHAR_W_DEF,
  parameter int unsigned CODE_W = lzw_pkg::CODE_W_DEF,
  localparam int unsigned ADDR_W = CODE_W + CHAR_W,
  localparam int unsigned NUM    = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              rd_hit_o,
  output logic [CODE_W-1:0] rd_code_o,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CODE_W-1:0] wr_code_i,
  input  logic              clr_en_i,
  input  logic [ADDR_W-1:0] clr_addr_i
);
  logic [NUM-1:0]    vld_q;
  logic [CODE_W-1:0] mem_q [NUM];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else begin
      if (wr_en_i)  vld_q[wr_addr_i]  <= 1'b1;
      if (clr_en_i) vld_q[clr_addr_i] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_code_i;
  end

  // synchronous read, same-cycle write forwarded
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_hit_o  <= 1'b0;
      rd_code_o <= '0;
    end else if (rd_en_i) begin
      if (wr_en_i && wr_addr_i == rd_addr_i) begin
        rd_hit_o  <= 1'b1;
        rd_code_o <= wr_code_i;
      end else begin
        rd_hit_o  <= vld_q[rd_addr_i];
        rd_code_o <= mem_q[rd_addr_i];
      end
    end
  end
endmodule

// File: rtl/lzw_code_alloc.sv
module lzw_code_alloc #(
  parameter int unsigned CHAR_W = lzw_pkg::CHAR_W_DEF,
  parameter int unsigned CODE_W = lzw_pkg::CODE_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              take_i,
  output logic [CODE_W:0]   nxt_o,
  output logic [CODE_W-1:0] code_o,
  output logic              full_o
);
  localparam logic [CODE_W:0] FIRST = (CODE_W+1)'(1 << CHAR_W);
  localparam logic [CODE_W:0] LIMIT = (CODE_W+1)'(1 << CODE_W);

  logic [CODE_W:0] nxt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        nxt_q <= FIRST;
    else if (restart_i) nxt_q <= FIRST;
    else if (take_i)    nxt_q <= nxt_q + 1'b1;
  end

  assign nxt_o  = nxt_q;
  assign code_o = nxt_q[CODE_W-1:0];
  assign full_o = (nxt_q == LIMIT);
endmodule

// File: rtl/lzw_clear_seq.sv
module lzw_clear_seq #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] cnt_q;
  logic              busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '1) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign addr_o = cnt_q;
endmodule

// File: rtl/lzw_enc.sv
module lzw_enc #(
  parameter int unsigned CHAR_W = lzw_pkg::CHAR_W_DEF,
  parameter int unsigned CODE_W = lzw_pkg::CODE_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [CHAR_W-1:0] in_char_i,
  input  logic              in_last_i,
  output logic              out_valid_o,
  output logic [CODE_W-1:0] out_code_o,
  output logic              out_last_o
);
  localparam int unsigned ADDR_W = CODE_W + CHAR_W;

  logic              have_j_q, pend_q, pend_last_q, flush_q;
  logic [CODE_W-1:0] cur_j_q, pend_j_q;
  logic [CHAR_W-1:0] pend_x_q;
  logic              out_valid_q, out_last_q;
  logic [CODE_W-1:0] out_code_q;

  logic              rd_hit;
  logic [CODE_W-1:0] rd_code;
  logic              clr_busy, clr_start;
  logic [ADDR_W-1:0] clr_addr;
  logic [CODE_W:0]   alloc_nxt;
  logic [CODE_W-1:0] alloc_code;
  logic              alloc_full;

  logic              res_miss, res_hit, acc, lookup, wr_en;
  logic [CODE_W-1:0] j_now;
  logic              emit, emit_last;
  logic [CODE_W-1:0] emit_code;

  assign res_miss = pend_q && !rd_hit;
  assign res_hit  = pend_q && rd_hit;
  // speculate a miss: after one, the new j is the pending character
  assign j_now    = res_miss ? CODE_W'(pend_x_q) : cur_j_q;

  assign in_ready_o = !clr_busy && !flush_q &&
                      (!pend_q || (res_miss && !alloc_full && !pend_last_q));
  assign acc    = in_valid_i && in_ready_o;
  assign lookup = acc && have_j_q;
  assign wr_en  = res_miss && !alloc_full;

  always_comb begin
    emit      = 1'b0;
    emit_last = 1'b0;
    emit_code = '0;
    clr_start = 1'b0;
    if (flush_q && !clr_busy) begin
      emit = 1'b1; emit_last = 1'b1; emit_code = cur_j_q; clr_start = 1'b1;
    end else if (res_miss) begin
      emit = 1'b1; emit_code = pend_j_q; clr_start = alloc_full;
    end else if (res_hit && pend_last_q) begin
      emit = 1'b1; emit_last = 1'b1; emit_code = rd_code; clr_start = 1'b1;
    end else if (acc && !have_j_q && in_last_i) begin
      emit = 1'b1; emit_last = 1'b1; emit_code = CODE_W'(in_char_i); clr_start = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_j_q    <= 1'b0;
      pend_q      <= 1'b0;
      pend_last_q <= 1'b0;
      flush_q     <= 1'b0;
      cur_j_q     <= '0;
      pend_j_q    <= '0;
      pend_x_q    <= '0;
      out_valid_q <= 1'b0;
      out_last_q  <= 1'b0;
      out_code_q  <= '0;
    end else begin
      out_valid_q <= emit;
      out_last_q  <= emit_last;
      if (emit) out_code_q <= emit_code;
      pend_q <= lookup;
      if (lookup) begin
        pend_j_q    <= j_now;
        pend_x_q    <= in_char_i;
        pend_last_q <= in_last_i;
      end
      if (res_miss) begin
        cur_j_q <= CODE_W'(pend_x_q);
        if (pend_last_q) flush_q <= 1'b1;
      end
      if (res_hit) begin
        cur_j_q <= rd_code;
        if (pend_last_q) have_j_q <= 1'b0;
      end
      if (flush_q && !clr_busy) begin
        flush_q  <= 1'b0;
        have_j_q <= 1'b0;
      end
      if (acc && !have_j_q) begin
        cur_j_q  <= CODE_W'(in_char_i);
        have_j_q <= !in_last_i;
      end
    end
  end

  lzw_bptab #(.CHAR_W(CHAR_W), .CODE_W(CODE_W)) u_tab (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_en_i    (lookup),
    .rd_addr_i  ({j_now, in_char_i}),
    .rd_hit_o   (rd_hit),
    .rd_code_o  (rd_code),
    .wr_en_i    (wr_en),
    .wr_addr_i  ({pend_j_q, pend_x_q}),
    .wr_code_i  (alloc_code),
    .clr_en_i   (clr_busy),
    .clr_addr_i (clr_addr)
  );

  lzw_code_alloc #(.CHAR_W(CHAR_W), .CODE_W(CODE_W)) u_alloc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (clr_start),
    .take_i    (wr_en),
    .nxt_o     (alloc_nxt),
    .code_o    (alloc_code),
    .full_o    (alloc_full)
  );

  lzw_clear_seq #(.ADDR_W(ADDR_W)) u_clr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (clr_start),
    .busy_o  (clr_busy),
    .addr_o  (clr_addr)
  );

  assign out_valid_o = out_valid_q;
  assign out_code_o  = out_code_q;
  assign out_last_o  = out_last_q;
endmodule

// File: rtl/lzw_enc_chk.sv
module lzw_enc_chk #(
  parameter int unsigned CODE_W = 6
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            in_ready_o,
  input logic            out_valid_o,
  input logic            out_last_o,
  input logic            clr_busy,
  input logic            res_hit,
  input logic            res_miss,
  input logic            pend_last_q,
  input logic            wr_en,
  input logic            alloc_full,
  input logic [CODE_W:0] alloc_nxt
);
  AST_CLEAR_BLOCKS_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_busy |-> !in_ready_o); // R10
  AST_LAST_HAS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> out_valid_o); // R6
  AST_LAST_THEN_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> clr_busy); // R10
  AST_HIT_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_hit && !pend_last_q) |=> !out_valid_o); // R4
  AST_CODE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> alloc_nxt == (CODE_W+1)'($past(alloc_nxt) + 1'b1)); // R5
  AST_FULL_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_miss && alloc_full) |=> (clr_busy && out_valid_o)); // R9
endmodule

bind lzw_enc lzw_enc_chk #(.CODE_W(CODE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_last_o  (out_last_o),
  .clr_busy    (clr_busy),
  .res_hit     (res_hit),
  .res_miss    (res_miss),
  .pend_last_q (pend_last_q),
  .wr_en       (wr_en),
  .alloc_full  (alloc_full),
  .alloc_nxt   (alloc_nxt)
);

// File: tb/lzw_enc_test.sv
module lzw_enc_test;
  localparam int CW    = 2;
  localparam int KW    = 6;
  localparam int NUM   = 1 << (CW + KW);
  localparam int ALPHA = 1 << CW;
  localparam int LIM   = 1 << KW;
  localparam int NV    = 5;
  // stimulus / expected vectors (a=0 b=1 c=2 d=3)
  localparam int VLEN  [NV]    = '{9, 1, 4, 4, 4};
  localparam int VCH   [NV][9] = '{'{2,1,2,1,2,1,2,3,0}, '{0,0,0,0,0,0,0,0,0},
                                   '{0,0,0,0,0,0,0,0,0}, '{0,1,0,1,0,0,0,0,0},
                                   '{3,2,1,0,0,0,0,0,0}};
  localparam int VNEXP [NV]    = '{6, 1, 3, 3, 4};
  localparam int VEXP  [NV][6] = '{'{2,1,4,6,3,0}, '{0,0,0,0,0,0}, '{0,4,0,0,0,0},
                                   '{0,1,4,0,0,0}, '{3,2,1,0,0,0}};
  localparam int VSTALL[NV]    = '{3, 0, 1, 0, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [CW-1:0] in_char = '0;
  logic in_ready, out_valid, out_last;
  logic [KW-1:0] out_code;

  always #2 clk = ~clk;

  lzw_enc #(.CHAR_W(CW), .CODE_W(KW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_char_i(in_char), .in_last_i(in_last), .out_valid_o(out_valid),
    .out_code_o(out_code), .out_last_o(out_last));

  int n_chk = 0, n_err = 0;
  int got_code[$];
  bit got_last[$];
  bit counting = 0;
  int clr_run = 0, clr_len = 0, ends = 0;

  always @(negedge clk) begin
    if (out_valid) begin
      got_code.push_back(int'(out_code));
      got_last.push_back(out_last);
    end
    if (out_valid && out_last) begin counting = 1; clr_run = 0; end
    if (counting) begin
      if (!in_ready) clr_run++;
      else begin counting = 0; clr_len = clr_run; ends++; end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input int ch, input bit last, input int gap, inout int stalls);
    for (int g = 0; g < gap; g++) begin @(negedge clk); in_valid = 1'b0; end
    @(negedge clk);
    in_valid = 1'b1; in_char = CW'(ch); in_last = last;
    while (!in_ready) begin stalls++; @(negedge clk); end
  endtask

  task automatic run_stream(input int s[$], input int gap, output int stalls);
    int e0;
    stalls = 0;
    while (!in_ready) @(negedge clk);
    got_code.delete(); got_last.delete();
    e0 = ends;
    for (int i = 0; i < s.size(); i++) send(s[i], i == s.size() - 1, gap, stalls);
    @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
    while (ends == e0) @(negedge clk);
  endtask

  task automatic model(input int s[$], output int e[$], output int nclr);
    int t[NUM];
    int nx, j;
    e = {}; nclr = 0; nx = ALPHA;
    foreach (t[i]) t[i] = -1;
    j = s[0];
    for (int i = 1; i < s.size(); i++) begin
      int a;
      a = j * ALPHA + s[i];
      if (t[a] >= 0) j = t[a];
      else begin
        e.push_back(j);
        if (nx == LIM) begin
          foreach (t[k]) t[k] = -1;
          nx = ALPHA; nclr++;
        end else begin
          t[a] = nx; nx++;
        end
        j = s[i];
      end
    end
    e.push_back(j);
  endtask

  task automatic cmp(input int e[$], input string req);
    chk(got_code.size() == e.size(), {req, " code count"}, got_code.size(), e.size());
    for (int i = 0; i < e.size() && i < got_code.size(); i++) begin
      chk(got_code[i] == e[i], {req, " code"}, got_code[i], e[i]);
      chk(got_last[i] == (i == e.size() - 1), "R6 last flag", int'(got_last[i]),
          int'(i == e.size() - 1));
    end
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int s[$];
    int e[$];
    int st, nclr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);

    // R2 R3 R4 R5 R7 R8 R11 via vector table
    for (int v = 0; v < NV; v++) begin
      s = {}; e = {};
      for (int i = 0; i < VLEN[v]; i++) s.push_back(VCH[v][i]);
      for (int i = 0; i < VNEXP[v]; i++) e.push_back(VEXP[v][i]);
      run_stream(s, 0, st);
      cmp(e, v == 2 ? "R11" : (v == 1 ? "R2" : "R3 R4 R5"));
      chk(st == VSTALL[v], v == 4 ? "R7 no stall on misses" : "R8 hit stall", st, VSTALL[v]);
      chk(clr_len == NUM, "R10 clear length", clr_len, NUM);
    end

    // gapped input: same codes, hits resolve in the gaps
    s = {}; e = {};
    for (int i = 0; i < 9; i++) s.push_back(VCH[0][i]);
    for (int i = 0; i < 6; i++) e.push_back(VEXP[0][i]);
    run_stream(s, 2, st);
    cmp(e, "R3 gapped");
    chk(st == 0, "R8 no stall when idle", st, 0);

    // repeat: dictionary restarts per stream
    run_stream(s, 0, st);
    cmp(e, "R12 repeat");

    // long stream forcing code-space exhaustion
    begin
      logic [15:0] lf;
      lf = 16'hACE1;
      s = {};
      for (int i = 0; i < 400; i++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        s.push_back(int'(lf[1:0]));
      end
    end
    model(s, e, nclr);
    run_stream(s, 0, st);
    cmp(e, "R9 full restart");
    chk(nclr > 0, "R9 stream reaches full", nclr, 1);

    // reset in mid-stream, then a clean stream
    st = 0;
    for (int i = 0; i < 5; i++) send(VCH[0][i], 1'b0, 0, st);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after mid reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready after mid reset", int'(in_ready), 1);
    s = {}; e = {};
    for (int i = 0; i < 9; i++) s.push_back(VCH[0][i]);
    for (int i = 0; i < 6; i++) e.push_back(VEXP[0][i]);
    run_stream(s, 0, st);
    cmp(e, "R1 after mid reset");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule